// File: doc/BRIEF.md
# Battery Charge/Discharge Switch Enable Controller

This block drives the enable lines for the charge switch and the discharge switch of a battery pack. Software controls both switches, and leaves the deep-undervoltage recovery mode, through one 8-bit control/status register. The register sits on a simple write strobe, address and data bus, and its read data is returned combinationally.

An autonomous over-current protection input overrides software. While it is high, both enables are forced low and the stored enable bits are cleared. Recovery mode is also dropped, so the charge path cannot be opened during a fault. When protection clears, a hold-off counter fed by a 1 kHz tick keeps software from re-enabling either switch until `HOLD_TICKS` ticks (1 s by default) have been counted. A power-off input also forces the switches off. An asynchronous active-low reset turns everything off at once.

Register layout at `REG_ADDR`:
- bit 0: charge enable.
- bit 1: discharge enable.
- bit 2: recovery exit, write 1 to act; reads 1 once recovery mode has been left.
- bit 3: busy, read-only.
- The remaining bits read 0.

Top module: `fet_enable_ctrl`

## Requirements
- R1: A write to `REG_ADDR` that is not blocked stores data bit 0 as the charge enable and bit 1 as the discharge enable. The outputs `chg_en_o` and `dsg_en_o` follow in the cycle after the write edge.
- R2: While `prot_i` is high, `chg_en_o` and `dsg_en_o` are low in the same cycle (with `SYNC_STAGES`=0). The stored enables are cleared at the next clock edge.
- R3: A write of the enable bits is ignored while protection is active or the lockout counter is non-zero.
- R4: After `prot_i` falls, the lockout lasts until `HOLD_TICKS` cycles with `tick_i` high have been seen. A new assertion of `prot_i` restarts the count from the full value.
- R5: When the lockout ends, both enables stay low until software writes them again.
- R6: Recovery mode (`recov_mode_o`=1) is active after reset. Writing 1 to bit 2 leaves it from the next cycle, and writing 0 to bit 2 has no effect. Read bit 2 is the inverse of the mode, so it reads 1 once the mode has been left.
- R7: A clock edge that sees protection active clears recovery mode.
- R8: While `pwroff_i` is high, both enable outputs are low in the same cycle and the stored enables are cleared. Enable writes are ignored during this time.
- R9: Read bit 3 is 1 while `prot_i` is high or the lockout counter is non-zero.
- R10: While `rst_ni` is low, both enables and `recov_mode_o` are low with no clock. After release, the enables are off, recovery mode is on and there is no lockout.
- R11: Writes to any address other than `REG_ADDR` change nothing. Reads at other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 kHz single-cycle tick for the hold-off counter |
| prot_i | input | 1 | Current-protection fault from the protection circuit |
| pwroff_i | input | 1 | Power-off request, forces both switches off |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| recov_mode_o | output | 1 | Deep-undervoltage recovery mode active |

## Verification
The forcing paths from protection, power-off and reset act on the outputs within the same cycle. Register writes, the clearing of state, the exit from recovery mode and counter steps all show one clock edge later. The bench changes its inputs one time unit after a rising edge and samples every output one time unit after the following edge. A cycle model in the bench, advanced at that same edge, gives the expected values. The asynchronous reset is checked between edges, and the lockout end is checked at exactly tick 999 and tick 1000.

// File: rtl/fet_ctl_pkg.sv
package fet_ctl_pkg;
   // bit positions inside the control/status register (software contract)
   localparam int unsigned CHG_BIT  = 0;
   localparam int unsigned DSG_BIT  = 1;
   localparam int unsigned RCV_BIT  = 2;
   localparam int unsigned BUSY_BIT = 3;
   localparam int unsigned MIN_DATA_W = BUSY_BIT + 1;

   typedef struct packed {
      logic dsg;
      logic chg;
   } fet_pair_t;
endpackage

// File: rtl/fet_in_sync.sv
module fet_in_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES > 4) begin : g_bad_stages
      $error("fet_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else if (STAGES == 1) chain_q <= d_i;
         else chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/fet_holdoff_timer.sv
module fet_holdoff_timer #(
   parameter int unsigned HOLD_TICKS = 1000,
   localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fault_i,
   input  logic tick_i,
   output logic locked_o,
   output logic busy_o
);
   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("fet_holdoff_timer: HOLD_TICKS must be at least 1");
   end

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (fault_i) cnt_q <= LOAD;
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign locked_o = (cnt_q != '0);
   assign busy_o   = fault_i | locked_o;

   // R4
   load_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> cnt_q == LOAD);
   // R4
   tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fault_i && tick_i && locked_o) |=> cnt_q == ($past(cnt_q) - CNT_W'(1)));
   // R4
   hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fault_i && !tick_i) |=> $stable(cnt_q));
   // R4
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LOAD);
endmodule

// File: rtl/fet_ctl_regs.sv
module fet_ctl_regs
   import fet_ctl_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      wr_hit_i,
   input  fet_pair_t wr_en_bits_i,
   input  logic      wr_rcv_exit_i,
   input  logic      fault_i,
   input  logic      pwroff_i,
   input  logic      locked_i,
   output fet_pair_t en_q_o,
   output logic      recov_q_o
);
   fet_pair_t en_q;
   logic      recov_q;
   logic      blocked;

   assign blocked = fault_i | locked_i | pwroff_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (fault_i || pwroff_i) begin
         en_q <= '0;
      end else if (wr_hit_i && !locked_i) begin
         en_q <= wr_en_bits_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) recov_q <= 1'b1;
      else if (fault_i) recov_q <= 1'b0;
      else if (wr_hit_i && wr_rcv_exit_i) recov_q <= 1'b0;
   end

   assign en_q_o    = en_q;
   assign recov_q_o = recov_q;

   // R3
   blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blocked && wr_hit_i) |=> en_q == '0);
   // R7
   fault_exits_recov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> !recov_q);
   // R6
   recov_exit_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit_i && wr_rcv_exit_i) |=> !recov_q);
   // R6
   recov_never_returns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !recov_q |=> !recov_q);
endmodule

// File: rtl/fet_enable_ctrl.sv
module fet_enable_ctrl
   import fet_ctl_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned REG_ADDR    = 0,
   parameter int unsigned HOLD_TICKS  = 1000,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              prot_i,
   input  logic              pwroff_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              chg_en_o,
   output logic              dsg_en_o,
   output logic              recov_mode_o
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("fet_enable_ctrl: DATA_W too small for register fields");
   end
   if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("fet_enable_ctrl: REG_ADDR does not fit ADDR_W");
   end

   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   logic      prot_s, pwroff_s;
   logic      addr_hit, wr_hit;
   logic      locked, busy;
   logic      recov_q;
   fet_pair_t en_q, wr_bits;

   fet_in_sync #(.STAGES(SYNC_STAGES)) u_sync_prot (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(prot_i), .q_o(prot_s));
   fet_in_sync #(.STAGES(SYNC_STAGES)) u_sync_pwroff (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwroff_i), .q_o(pwroff_s));

   assign addr_hit    = (addr_i == MY_ADDR);
   assign wr_hit      = wr_en_i & addr_hit;
   assign wr_bits.chg = wr_data_i[CHG_BIT];
   assign wr_bits.dsg = wr_data_i[DSG_BIT];

   fet_holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(prot_s), .tick_i(tick_i),
      .locked_o(locked), .busy_o(busy));

   fet_ctl_regs u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_hit_i(wr_hit), .wr_en_bits_i(wr_bits),
      .wr_rcv_exit_i(wr_data_i[RCV_BIT]), .fault_i(prot_s), .pwroff_i(pwroff_s),
      .locked_i(locked), .en_q_o(en_q), .recov_q_o(recov_q));

   // forcing paths act without waiting for a clock edge
   logic force_off;
   assign force_off    = prot_s | pwroff_s | ~rst_ni;
   assign chg_en_o     = en_q.chg & ~force_off;
   assign dsg_en_o     = en_q.dsg & ~force_off;
   assign recov_mode_o = recov_q & rst_ni;

   always_comb begin
      rd_data_o = '0;
      if (addr_hit) begin
         rd_data_o[CHG_BIT]  = chg_en_o;
         rd_data_o[DSG_BIT]  = dsg_en_o;
         rd_data_o[RCV_BIT]  = ~recov_mode_o;
         rd_data_o[BUSY_BIT] = busy;
      end
   end

   // R1
   chg_rise_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chg_en_o) |-> $past(wr_hit && !busy && !pwroff_s));
   // R1
   dsg_rise_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dsg_en_o) |-> $past(wr_hit && !busy && !pwroff_s));
   // R5
   lock_end_stays_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(locked) |-> (en_q == '0));
endmodule

// File: tb/tb_fet_enable_ctrl.sv
module tb_fet_enable_ctrl;
   localparam int unsigned HOLD = 1000;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       tick = 1'b0, prot = 1'b0, pwroff = 1'b0, wr = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       chg_en, dsg_en, recov;

   int n_checks = 0, n_fail = 0;

   // bench model state
   logic m_chg, m_dsg, m_rcv;
   int   m_cnt;

   always #5 clk = ~clk;

   fet_enable_ctrl dut (
      .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .prot_i(prot), .pwroff_i(pwroff),
      .wr_en_i(wr), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
      .chg_en_o(chg_en), .dsg_en_o(dsg_en), .recov_mode_o(recov));

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic exp_chg();
      return rst_ni & m_chg & ~prot & ~pwroff;
   endfunction
   function automatic logic exp_dsg();
      return rst_ni & m_dsg & ~prot & ~pwroff;
   endfunction
   function automatic logic [7:0] exp_rd();
      logic [7:0] r = '0;
      if (addr == 2'd0) begin
         r[0] = exp_chg();
         r[1] = exp_dsg();
         r[2] = ~(m_rcv & rst_ni);
         r[3] = prot | (m_cnt != 0);
      end
      return r;
   endfunction

   task automatic model_reset();
      m_chg = 0; m_dsg = 0; m_rcv = 1; m_cnt = 0;
   endtask

   // next-state rules taken from the requirements
   task automatic model_edge();
      logic wr_hit;
      wr_hit = wr && (addr == 2'd0);
      if (prot) begin
         m_chg = 0; m_dsg = 0; m_rcv = 0; m_cnt = HOLD;
      end else begin
         if (pwroff) begin
            m_chg = 0; m_dsg = 0;
         end else if (wr_hit && m_cnt == 0) begin
            m_chg = wdata[0]; m_dsg = wdata[1];
         end
         if (wr_hit && wdata[2]) m_rcv = 0;
         if (tick && m_cnt != 0) m_cnt--;
      end
   endtask

   task automatic compare_all();
      check("R2 chg_en_o", {7'b0, chg_en}, {7'b0, exp_chg()});
      check("R2 dsg_en_o", {7'b0, dsg_en}, {7'b0, exp_dsg()});
      check("R6 recov_mode_o", {7'b0, recov}, {7'b0, m_rcv & rst_ni});
      check("R9 rd_data_o", rdata, exp_rd());
   endtask

   // one clock: edge, model update, sample one unit later
   task automatic step();
      @(posedge clk);
      model_edge();
      #1;
      compare_all();
   endtask

   task automatic idle();
      wr = 0; tick = 0;
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      wr = 1; addr = a; wdata = d;
      step();
      wr = 0; addr = 2'd0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      #2;
      // R10 outputs during reset
      check("R10 chg in reset", {7'b0, chg_en}, 8'd0);
      check("R10 recov in reset", {7'b0, recov}, 8'd0);
      repeat (2) @(posedge clk);
      #1 rst_ni = 1;
      #1;
      check("R10 recov after release", {7'b0, recov}, 8'd1);
      check("R10 rd after release", rdata, 8'h00);
      step();

      // R1 enable both, then charge only
      do_write(2'd0, 8'h03); step();
      check("R1 both on", {6'b0, dsg_en, chg_en}, 8'h03);
      do_write(2'd0, 8'h01); step();
      check("R1 charge only", {6'b0, dsg_en, chg_en}, 8'h01);

      // R11 other address ignored, reads 0
      do_write(2'd1, 8'h07); addr = 2'd1; #1;
      check("R11 read other addr", rdata, 8'h00);
      addr = 2'd0; step();
      check("R11 state kept", rdata[2:0], 8'h01);

      // R6 writing 0 to recovery bit keeps mode
      do_write(2'd0, 8'h01); step();
      check("R6 write 0 keeps mode", {7'b0, recov}, 8'd1);

      // R2 same-cycle force and R7 recovery exit
      prot = 1; #1;
      check("R2 immediate off", {6'b0, dsg_en, chg_en}, 8'h00);
      step();
      check("R7 recov dropped", {7'b0, recov}, 8'd0);
      check("R9 busy during prot", {7'b0, rdata[3]}, 8'd1);
      do_write(2'd0, 8'h03); step();
      check("R3 write in prot ignored", {6'b0, dsg_en, chg_en}, 8'h00);

      // R4 lockout: exact 999/1000 tick boundary, with restart
      prot = 0; tick = 1;
      repeat (500) step();
      prot = 1; step(); prot = 0;
      repeat (HOLD - 1) step();
      tick = 0; step();
      check("R4 still locked at 999", {7'b0, rdata[3]}, 8'd1);
      do_write(2'd0, 8'h03); step();
      check("R3 write in lockout ignored", {6'b0, dsg_en, chg_en}, 8'h00);
      tick = 1; step(); tick = 0; step();
      check("R4 unlocked at 1000", {7'b0, rdata[3]}, 8'd0);
      check("R5 stays off", {6'b0, dsg_en, chg_en}, 8'h00);
      do_write(2'd0, 8'h02); step();
      check("R5 rewrite enables", {6'b0, dsg_en, chg_en}, 8'h02);

      // R8 power-off
      pwroff = 1; #1;
      check("R8 immediate off", {6'b0, dsg_en, chg_en}, 8'h00);
      do_write(2'd0, 8'h03);
      pwroff = 0; step();
      check("R8 cleared and write ignored", {6'b0, dsg_en, chg_en}, 8'h00);

      // R10 asynchronous reset between edges
      do_write(2'd0, 8'h07); step();
      check("R6 exit recov", {7'b0, recov, rdata[2]}, 8'h01);
      rst_ni = 0; #1;
      check("R10 async off", {5'b0, recov, dsg_en, chg_en}, 8'h00);
      model_reset();
      @(posedge clk); #1 rst_ni = 1; step();

      // random mix
      for (int i = 0; i < 20000; i++) begin
         if (prot) prot = ($urandom % 30) != 0;
         else prot = ($urandom % 2500) == 0;
         if ($urandom % 150 == 0) pwroff = ~pwroff;
         tick  = ($urandom % 3) != 0;
         wr    = ($urandom % 4) == 0;
         addr  = (($urandom % 5) == 0) ? 2'($urandom) : 2'd0;
         wdata = 8'($urandom);
         if (($urandom % 8) != 0) wdata[2] = 1'b0;
         step();
      end

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule